// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers seven level-sensitive interrupt sources into a pending (cause) register and gates them with an enable (mask) register. It raises a single combined interrupt line towards a parent interrupt controller whenever an enabled source is pending. A simple synchronous register port lets software read and write both registers.

The cause register is a plain read/write register. It is not write-one-to-clear. Every write stores the supplied value, so software can clear pending bits by writing 0 and can also raise interrupts itself by writing 1. A source that is high keeps re-setting its bit, so a level that is still active cannot be lost to a software clear. Typical bring-up writes 0 to the mask and then 0 to the cause. After that, software enables the sources it wants.

Top module: `intr_cause_ctrl`

## Requirements
- R1: After reset, the cause and mask registers both read 0 and `irq_o` is low.
- R2: A write to offset 0x50 while all sources are low stores bits 6:0 of the write data into the cause register exactly. A 1 sets a pending bit and a 0 clears it. The new value is readable and effective after the clock edge of the write.
- R3: A write to offset 0x54 stores bits 6:0 of the write data into the mask register, where bit n = 1 enables source n and 0 disables it. The stored value reads back at 0x54.
- R4: `irq_o` is high exactly when the bitwise AND of cause and mask is non-zero. It follows the registers combinationally.
- R5: A source n that is high at a clock edge sets cause bit n at that edge. The bit stays set after the source falls, until software writes it to 0.
- R6: When a cause write tries to clear bit n at the same edge that source n is high, bit n stays 1. The other bits still take the written value.
- R7: Bits 31:7 of both registers read as 0, and writes to them have no effect.
- R8: Reads of any offset other than 0x50 and 0x54 return 0. Writes to such offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 7 | Level interrupt sources, bit n is source n |
| reg_wr_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt towards the parent controller |

## Verification
The hardware set from a high source and a software write to the cause register can happen in the same cycle, and the source must win on its own bit. The bench provokes this by holding a source high across the edge where a cause write drives that bit to 0 while it sets or clears the other bits. It then judges the result by reading the cause register back: the held bit must be 1 and every other bit must equal the written data. Exhaustive sweeps of all mask and cause combinations check the combined output arithmetically against the AND-reduction.

// File: rtl/intr_cause_pkg.sv
package intr_cause_pkg;

  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 8;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // Next cause value: software write replaces, live sources always set.
  function automatic src_vec_t cause_next(input src_vec_t held,
                                          input logic     wr,
                                          input src_vec_t wval,
                                          input src_vec_t lvl);
    src_vec_t base;
    base = wr ? wval : held;
    return base | lvl;
  endfunction

  // Enabled-and-pending vector.
  function automatic src_vec_t pending_vec(input src_vec_t cause,
                                           input src_vec_t mask);
    return cause & mask;
  endfunction

endpackage

// File: rtl/intr_reg_decode.sv
module intr_reg_decode
  import intr_cause_pkg::*;
#(
  parameter int unsigned N_SRC    = NUM_SRC,
  parameter int unsigned DW       = DATA_W,
  parameter int unsigned AW       = ADDR_W,
  parameter logic [AW-1:0] CAUSE_OFF = 8'h50,
  parameter logic [AW-1:0] MASK_OFF  = 8'h54
) (
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [N_SRC-1:0] cause_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic            cause_wr_o,
  output logic            mask_wr_o,
  output logic [DW-1:0]   rdata_o
);
  localparam int unsigned PAD_W = DW - N_SRC;

  logic hit_cause, hit_mask;

  assign hit_cause  = (addr_i == CAUSE_OFF);
  assign hit_mask   = (addr_i == MASK_OFF);
  assign cause_wr_o = wr_i & hit_cause;
  assign mask_wr_o  = wr_i & hit_mask;

  always_comb begin
    rdata_o = '0;
    if (hit_cause)     rdata_o = {{PAD_W{1'b0}}, cause_i};
    else if (hit_mask) rdata_o = {{PAD_W{1'b0}}, mask_i};
  end
endmodule

// File: rtl/intr_cause_store.sv
module intr_cause_store
  import intr_cause_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] wval_i,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] cause_o
);
  logic [N_SRC-1:0] nxt;

  always_comb nxt = cause_next(cause_o, wr_i, wval_i, src_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_o <= '0;
    else        cause_o <= nxt;
  end
endmodule

// File: rtl/intr_mask_store.sv
module intr_mask_store
  import intr_cause_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] wval_i,
  input  logic [N_SRC-1:0] cause_i,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '0;
    else if (wr_i) mask_o <= wval_i;
  end

  assign pend_o = pending_vec(cause_i, mask_o);
endmodule

// File: rtl/intr_cause_ctrl.sv
module intr_cause_ctrl
  import intr_cause_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned AW    = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             reg_wr_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o
);
  logic             cause_wr_evt;
  logic             mask_wr_evt;
  logic [N_SRC-1:0] cause_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] pend_vec;
  logic [N_SRC-1:0] wval;

  assign wval = reg_wdata_i[N_SRC-1:0];

  intr_reg_decode #(.N_SRC(N_SRC), .DW(DW), .AW(AW)) u_dec (
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .cause_i    (cause_q),
    .mask_i     (mask_q),
    .cause_wr_o (cause_wr_evt),
    .mask_wr_o  (mask_wr_evt),
    .rdata_o    (reg_rdata_o)
  );

  intr_cause_store #(.N_SRC(N_SRC)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (cause_wr_evt),
    .wval_i  (wval),
    .src_i   (src_i),
    .cause_o (cause_q)
  );

  intr_mask_store #(.N_SRC(N_SRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_wr_evt),
    .wval_i  (wval),
    .cause_i (cause_q),
    .mask_o  (mask_q),
    .pend_o  (pend_vec)
  );

  assign irq_o = |pend_vec;
endmodule

// File: rtl/intr_cause_chk.sv
module intr_cause_chk #(
  parameter int unsigned N_SRC = 7,
  parameter int unsigned DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_i,
  input logic [DW-1:0]    reg_wdata_i,
  input logic [DW-1:0]    reg_rdata_o,
  input logic             irq_o,
  input logic             cause_wr_evt,
  input logic             mask_wr_evt,
  input logic [N_SRC-1:0] cause_q,
  input logic [N_SRC-1:0] mask_q
);
  p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((cause_q & mask_q) != '0));

  p_src_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i != '0) |=> ((cause_q & $past(src_i)) == $past(src_i)));

  p_src_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr_evt |=> (cause_q == ($past(reg_wdata_i[N_SRC-1:0]) | $past(src_i))));

  p_cause_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cause_wr_evt && src_i == '0) |=> $stable(cause_q));

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_evt |=> $stable(mask_q));

  p_mask_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_evt |=> (mask_q == $past(reg_wdata_i[N_SRC-1:0])));

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[DW-1:N_SRC] == '0);
endmodule

bind intr_cause_ctrl intr_cause_chk #(.N_SRC(N_SRC), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_i        (src_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .irq_o        (irq_o),
  .cause_wr_evt (cause_wr_evt),
  .mask_wr_evt  (mask_wr_evt),
  .cause_q      (cause_q),
  .mask_q       (mask_q)
);

// File: tb/tb_intr_cause_ctrl.sv
module tb_intr_cause_ctrl;
  localparam logic [7:0] OFF_C = 8'h50;
  localparam logic [7:0] OFF_M = 8'h54;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  src = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intr_cause_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic exp_irq(input logic [6:0] c, input logic [6:0] m);
    int n;
    n = 0;
    for (int i = 0; i < 7; i++) if (c[i] && m[i]) n++;
    return n > 0;
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_reg(OFF_C, v); check("R1 cause", v, 32'h0);
    rd_reg(OFF_M, v); check("R1 mask", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R4 exhaustive sweep
    for (int m = 0; m < 128; m++) begin
      wr_reg(OFF_M, 32'(m));
      rd_reg(OFF_M, v); check("R3 mask readback", v, 32'(m));
      for (int c = 0; c < 128; c++) begin
        wr_reg(OFF_C, 32'(c));
        if (m == 127 || c == m) begin
          rd_reg(OFF_C, v); check("R2 cause readback", v, 32'(c));
        end
        check("R4 irq", {31'h0, irq}, {31'h0, exp_irq(7'(c), 7'(m))});
      end
    end

    // R7 upper bits ignored
    wr_reg(OFF_C, 32'hFFFF_FF80);
    rd_reg(OFF_C, v); check("R7 cause upper", v, 32'h0);
    wr_reg(OFF_M, 32'hFFFF_FFA5);
    rd_reg(OFF_M, v); check("R7 mask upper", v, 32'h25);

    // R8 unmapped offsets
    wr_reg(OFF_C, 32'h0000_0011);
    wr_reg(8'h58, 32'hFFFF_FFFF);
    wr_reg(8'h30, 32'hFFFF_FFFF);
    rd_reg(8'h58, v); check("R8 unmapped read", v, 32'h0);
    rd_reg(OFF_C, v); check("R8 cause untouched", v, 32'h11);
    rd_reg(OFF_M, v); check("R8 mask untouched", v, 32'h25);

    // R5 source latches
    wr_reg(OFF_C, 32'h0);
    wr_reg(OFF_M, 32'h0);
    check("R4 irq masked off", {31'h0, irq}, 32'h0);
    @(negedge clk); src = 7'h44;
    @(negedge clk); src = 7'h00;
    repeat (3) @(negedge clk);
    rd_reg(OFF_C, v); check("R5 latched", v, 32'h44);
    check("R5 masked irq low", {31'h0, irq}, 32'h0);
    wr_reg(OFF_M, 32'h04);
    check("R5 irq after enable", {31'h0, irq}, 32'h1);
    wr_reg(OFF_C, 32'h40);
    check("R5 irq after clear", {31'h0, irq}, 32'h0);
    rd_reg(OFF_C, v); check("R5 partial clear", v, 32'h40);

    // R6 source wins against clearing write in same cycle
    wr_reg(OFF_C, 32'h7F);
    @(negedge clk);
    src = 7'h08; wr = 1'b1; addr = OFF_C; wdata = 32'h03;
    @(negedge clk);
    wr = 1'b0; src = 7'h00;
    rd_reg(OFF_C, v); check("R6 held bit", v, 32'h0B);
    wr_reg(OFF_C, 32'h0);
    rd_reg(OFF_C, v); check("R6 cleared after source low", v, 32'h0);

    // R2 software-raised interrupt
    wr_reg(OFF_M, 32'h7F);
    wr_reg(OFF_C, 32'h20);
    check("R2 software raise irq", {31'h0, irq}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule